// File: doc/BRIEF.md
# Signed Division Sign-Adjust Wrapper

This block turns an external unsigned long-division core into a truncating signed divider. It works in two widths: a word mode (double-width dividend over a W-bit divisor) and a byte mode (half-width fields). A pre-stage converts a signed dividend and divisor to their magnitudes before handing them to the core. It records the sign of the final quotient in a flag that starts cleared and is toggled once for each negative operand. The double-width dividend is negated half by half: the low half is two's-complemented, and the upper half is two's-complemented when the low half is zero and one's-complemented otherwise.

When the core answers, a post-stage applies the signs and reports a divide error. The quotient takes the toggled sign and the remainder takes the sign of the dividend. A divide error is raised when the core rejects the operation or, in signed mode, when the quotient magnitude has its top bit set. In unsigned mode the operands go to the core unchanged. A host starts an operation with a one-cycle `start` and receives a one-cycle `done` with registered results. The core is driven through the `core_*` port group.

Top module: `sdiv_wrap`

## Requirements
- R1: In unsigned mode (`is_signed`=0), `quotient` and `remainder` equal the unsigned quotient and remainder of `dividend` over `divisor`, and no signed overflow test is applied (a quotient with its top bit set is returned without error).
- R2: In signed mode, results follow truncating division. The quotient is negative when exactly one operand is negative, and the remainder carries the sign of the dividend. For example, -27/7 gives -3 rem -6, 27/-7 gives -3 rem 6, and -27/-7 gives 3 rem -6.
- R3: In signed mode, `div_err` is 1 when the unsigned quotient magnitude has its top bit set. This includes a true quotient of -2^(n-1), where n is the active width.
- R4: `div_err` is 1 whenever the core reports `core_err`. The core does this when the upper dividend half is at least the divisor, computed on the magnitudes in signed mode, so a zero divisor is always an error. This error takes priority over the signed overflow test.
- R5: When `div_err` is 1, `quotient` and `remainder` are 0.
- R6: In byte mode (`byte_mode`=1), only `dividend[W-1:0]` (upper half-field `[W-1:W/2]`, lower `[W/2-1:0]`) and `divisor[W/2-1:0]` are used; all other input bits are ignored. Results sit in bits `[W/2-1:0]` with zeros above, and the core receives `{W zeros, upper field, lower field}` with `core_byte`=1.
- R7: `start` is taken only when idle. `core_start` is a one-cycle pulse in the cycle after acceptance, and `done` is a one-cycle pulse in the cycle after `core_done`. A `start` while busy is ignored: it causes no extra core request and does not change the result.
- R8: After a signed operation, `flag_carry` and `flag_ovf` are 0.
- R9: The core receives the dividend and divisor magnitudes in signed mode and the raw operands in unsigned mode.
- R10: After reset, `done`, `div_err`, `core_start`, `quotient`, `remainder` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken when idle) |
| is_signed | input | 1 | 1 = signed division, 0 = unsigned |
| byte_mode | input | 1 | 1 = half-width operation |
| dividend | input | 2W | Double-width dividend |
| divisor | input | W | Divisor |
| done | output | 1 | One-cycle result strobe |
| quotient | output | W | Quotient |
| remainder | output | W | Remainder |
| div_err | output | 1 | Divide error |
| flag_carry | output | 1 | Carry status, cleared by signed operations |
| flag_ovf | output | 1 | Overflow status, cleared by signed operations |
| core_start | output | 1 | Request to the unsigned core |
| core_byte | output | 1 | Width select to the core |
| core_dividend | output | 2W | Dividend handed to the core |
| core_divisor | output | W | Divisor handed to the core |
| core_done | input | 1 | Core result strobe |
| core_quotient | input | W | Unsigned quotient from the core |
| core_remainder | input | W | Unsigned remainder from the core |
| core_err | input | 1 | Core rejected the operation |

## Verification
The bench builds the wrapper with W=8, so byte mode works on an 8-bit dividend and a 4-bit divisor. At that width every byte-mode operand pair can be swept in both signed and unsigned mode. This reaches every negation corner: zero low fields, the most negative dividend and divisor, and quotients of exactly -8 and +8. Word mode sweeps all 256 divisors against a set of dividends chosen for zero halves, extreme values and the small signed cases. A behavioural unsigned core in the bench answers requests and checks that it is handed magnitudes.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_mag.sv
// Magnitude of a split double-width dividend and a single-width divisor.
module sdiv_mag #(
  parameter int HW = 8
) (
  input  logic [HW-1:0] hi,
  input  logic [HW-1:0] lo,
  input  logic [HW-1:0] dvs,
  output logic [HW-1:0] mag_hi,
  output logic [HW-1:0] mag_lo,
  output logic [HW-1:0] mag_dvs,
  output logic          dvd_neg,
  output logic          dvs_neg
);
  logic lo_zero;

  always_comb begin
    dvd_neg = hi[HW-1];
    dvs_neg = dvs[HW-1];
    lo_zero = (lo == '0);
    // low half: plain two's complement
    mag_lo  = dvd_neg ? (~lo + HW'(1)) : lo;
    // upper half: carry from the low half only exists when it was zero
    if (!dvd_neg)     mag_hi = hi;
    else if (lo_zero) mag_hi = ~hi + HW'(1);
    else              mag_hi = ~hi;
    mag_dvs = dvs_neg ? (~dvs + HW'(1)) : dvs;
  end
endmodule

// File: rtl/sdiv_pre.sv
// Pre-stage: selects width, converts to magnitudes, builds the sign flag.
module sdiv_pre #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           is_signed,
  input  logic           byte_mode,
  output logic [2*W-1:0] core_dvd,
  output logic [W-1:0]   core_dvs,
  output logic           neg_quot,
  output logic           neg_rem
);
  localparam int HB = W / 2;

  logic [1:0][W-1:0] mh, ml, md;
  logic [1:0]        dn, dv;

  // index 0 = word width, index 1 = byte width
  for (genvar gi = 0; gi < 2; gi++) begin : g_width
    localparam int HW = W >> gi;
    logic [HW-1:0] mh_l, ml_l, md_l;
    sdiv_mag #(.HW(HW)) u_mag (
      .hi      (dividend[2*HW-1:HW]),
      .lo      (dividend[HW-1:0]),
      .dvs     (divisor[HW-1:0]),
      .mag_hi  (mh_l),
      .mag_lo  (ml_l),
      .mag_dvs (md_l),
      .dvd_neg (dn[gi]),
      .dvs_neg (dv[gi])
    );
    assign mh[gi] = W'(mh_l);
    assign ml[gi] = W'(ml_l);
    assign md[gi] = W'(md_l);
  end

  logic [W-1:0] raw_hi, raw_lo, raw_dvs, sel_hi, sel_lo, sel_dvs;
  logic         sign_flag;

  always_comb begin
    if (byte_mode) begin
      raw_hi  = W'(dividend[W-1:HB]);
      raw_lo  = W'(dividend[HB-1:0]);
      raw_dvs = W'(divisor[HB-1:0]);
    end else begin
      raw_hi  = dividend[2*W-1:W];
      raw_lo  = dividend[W-1:0];
      raw_dvs = divisor;
    end

    // sign flag starts clear, toggled per negative operand
    sign_flag = 1'b0;
    if (is_signed) begin
      if (dn[byte_mode]) sign_flag = ~sign_flag;
      if (dv[byte_mode]) sign_flag = ~sign_flag;
    end
    neg_quot = sign_flag;
    neg_rem  = is_signed & dn[byte_mode];

    sel_hi  = is_signed ? mh[byte_mode] : raw_hi;
    sel_lo  = is_signed ? ml[byte_mode] : raw_lo;
    sel_dvs = is_signed ? md[byte_mode] : raw_dvs;

    if (byte_mode) core_dvd = {{W{1'b0}}, sel_hi[HB-1:0], sel_lo[HB-1:0]};
    else           core_dvd = {sel_hi, sel_lo};
    core_dvs = sel_dvs;
  end
endmodule

// File: rtl/sdiv_post.sv
// Post-stage: overflow test, sign application, error zeroing.
module sdiv_post #(
  parameter int W = 16
) (
  input  logic         byte_mode,
  input  logic         is_signed,
  input  logic         neg_quot,
  input  logic         neg_rem,
  input  logic         core_err,
  input  logic [W-1:0] core_quot,
  input  logic [W-1:0] core_rem,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         err
);
  localparam int HB = W / 2;

  logic [W-1:0] mask, qm, rm;
  logic         q_top, ovf;

  always_comb begin
    mask  = byte_mode ? W'({HB{1'b1}}) : {W{1'b1}};
    qm    = core_quot & mask;
    rm    = core_rem & mask;
    q_top = byte_mode ? core_quot[HB-1] : core_quot[W-1];
    ovf   = is_signed & q_top;
    // core rejection wins; overflow only matters otherwise
    err   = core_err | ovf;
    if (err) begin
      quot = '0;
      rem  = '0;
    end else begin
      quot = (neg_quot ? (~qm + W'(1)) : qm) & mask;
      rem  = (neg_rem  ? (~rm + W'(1)) : rm) & mask;
    end
  end
endmodule

// File: rtl/sdiv_ctrl.sv
// Sequencer: idle -> launch core -> wait for core.
module sdiv_ctrl
  import sdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic core_done,
  output logic accept,
  output logic core_start,
  output logic capture
);
  sdiv_state_e state_q, state_d;

  always_comb begin
    accept     = (state_q == ST_IDLE) && start;
    core_start = (state_q == ST_LAUNCH);
    capture    = (state_q == ST_WAIT) && core_done;
    state_d    = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = ST_LAUNCH;
      ST_LAUNCH: state_d = ST_WAIT;
      ST_WAIT:   if (core_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R7: a completed operation returns to idle
  a_r7_idle_after_capture: assert property (@(posedge clk) disable iff (rst)
    capture |=> (state_q == ST_IDLE));
  // R7: one launch per accepted start
  a_r7_launch_then_wait: assert property (@(posedge clk) disable iff (rst)
    core_start |=> (state_q == ST_WAIT));
endmodule

// File: rtl/sdiv_wrap.sv
module sdiv_wrap #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           is_signed,
  input  logic           byte_mode,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           done,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           div_err,
  output logic           flag_carry,
  output logic           flag_ovf,
  output logic           core_start,
  output logic           core_byte,
  output logic [2*W-1:0] core_dividend,
  output logic [W-1:0]   core_divisor,
  input  logic           core_done,
  input  logic [W-1:0]   core_quotient,
  input  logic [W-1:0]   core_remainder,
  input  logic           core_err
);
  localparam int HB = W / 2;

  logic           accept, capture;
  logic [2*W-1:0] pre_dvd;
  logic [W-1:0]   pre_dvs;
  logic           pre_nq, pre_nr;
  logic           sig_q, byte_q, nq_q, nr_q;
  logic [W-1:0]   post_q, post_r;
  logic           post_err;

  sdiv_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .core_done  (core_done),
    .accept     (accept),
    .core_start (core_start),
    .capture    (capture)
  );

  sdiv_pre #(.W(W)) u_pre (
    .dividend  (dividend),
    .divisor   (divisor),
    .is_signed (is_signed),
    .byte_mode (byte_mode),
    .core_dvd  (pre_dvd),
    .core_dvs  (pre_dvs),
    .neg_quot  (pre_nq),
    .neg_rem   (pre_nr)
  );

  sdiv_post #(.W(W)) u_post (
    .byte_mode (byte_q),
    .is_signed (sig_q),
    .neg_quot  (nq_q),
    .neg_rem   (nr_q),
    .core_err  (core_err),
    .core_quot (core_quotient),
    .core_rem  (core_remainder),
    .quot      (post_q),
    .rem       (post_r),
    .err       (post_err)
  );

  // operation registers, loaded when a start is taken
  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q         <= 1'b0;
      byte_q        <= 1'b0;
      nq_q          <= 1'b0;
      nr_q          <= 1'b0;
      core_dividend <= '0;
      core_divisor  <= '0;
    end else if (accept) begin
      sig_q         <= is_signed;
      byte_q        <= byte_mode;
      nq_q          <= pre_nq;
      nr_q          <= pre_nr;
      core_dividend <= pre_dvd;
      core_divisor  <= pre_dvs;
    end
  end

  assign core_byte = byte_q;

  // result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      quotient   <= '0;
      remainder  <= '0;
      div_err    <= 1'b0;
      flag_carry <= 1'b0;
      flag_ovf   <= 1'b0;
    end else begin
      done <= capture;
      if (capture) begin
        quotient  <= post_q;
        remainder <= post_r;
        div_err   <= post_err;
        if (sig_q) begin
          flag_carry <= 1'b0;
          flag_ovf   <= 1'b0;
        end
      end
    end
  end

  // R7: core request lasts one cycle
  a_r7_core_start_pulse: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);
  // R7: core request only follows a start
  a_r7_launch_follows_start: assert property (@(posedge clk) disable iff (rst)
    core_start |-> $past(start));
  // R7: done lasts one cycle and follows the core strobe
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_follows_core: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(core_done));
  // R5: errors carry zero results
  a_r5_err_zero: assert property (@(posedge clk) disable iff (rst)
    (done && div_err) |-> (quotient == '0 && remainder == '0));
  // R4: a core rejection is always reported
  a_r4_core_err: assert property (@(posedge clk) disable iff (rst)
    (capture && core_err) |=> (done && div_err));
  // R3: signed magnitude with top bit set is an error
  a_r3_signed_overflow: assert property (@(posedge clk) disable iff (rst)
    (capture && sig_q && (byte_q ? core_quotient[HB-1] : core_quotient[W-1]))
      |=> (done && div_err));
  // R6: byte results leave the upper half clear
  a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (done && byte_q) |-> (quotient[W-1:HB] == '0 && remainder[W-1:HB] == '0));
endmodule

// File: tb/sdiv_wrap_bench.sv
module sdiv_wrap_bench;
  localparam int W  = 8;
  localparam int HB = W / 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           is_signed = 1'b0;
  logic           byte_mode = 1'b0;
  logic [2*W-1:0] dividend = '0;
  logic [W-1:0]   divisor = '0;
  logic           done, div_err, flag_carry, flag_ovf;
  logic [W-1:0]   quotient, remainder;
  logic           core_start, core_byte;
  logic [2*W-1:0] core_dividend;
  logic [W-1:0]   core_divisor;
  logic           core_done = 1'b0;
  logic [W-1:0]   core_quotient = '0;
  logic [W-1:0]   core_remainder = '0;
  logic           core_err = 1'b0;

  sdiv_wrap #(.W(W)) u_sdiv_wrap (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .byte_mode(byte_mode), .dividend(dividend), .divisor(divisor),
    .done(done), .quotient(quotient), .remainder(remainder),
    .div_err(div_err), .flag_carry(flag_carry), .flag_ovf(flag_ovf),
    .core_start(core_start), .core_byte(core_byte),
    .core_dividend(core_dividend), .core_divisor(core_divisor),
    .core_done(core_done), .core_quotient(core_quotient),
    .core_remainder(core_remainder), .core_err(core_err)
  );

  always #4 clk = ~clk;  // 125 MHz

  int     nchk = 0;
  int     nfail = 0;
  int     cyc = 0;
  int     core_done_cyc = 0;
  int     starts = 0;
  int     cnt = 0;
  longint exp_cdvd = 0;
  longint exp_cdvs = 0;
  logic [W-1:0] obs_q, obs_r;
  logic         obs_e;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural unsigned core, 3 cycles of latency
  always @(negedge clk) begin
    if (rst) begin
      cnt = 0;
      core_done = 1'b0;
    end else begin
      core_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          core_done = 1'b1;
          core_done_cyc = cyc;
        end
      end else if (core_start) begin
        int     n;
        longint dm, v, hi;
        starts++;
        n  = core_byte ? HB : W;
        dm = longint'(core_dividend) & ((64'd1 << (2 * n)) - 1);
        v  = longint'(core_divisor) & ((64'd1 << n) - 1);
        hi = dm >> n;
        // R9: the core sees magnitudes or raw operands
        chk(longint'(core_dividend) == exp_cdvd, "R9", "core dividend",
            longint'(core_dividend), exp_cdvd);
        chk(longint'(core_divisor) == exp_cdvs, "R9", "core divisor",
            longint'(core_divisor), exp_cdvs);
        if (hi >= v) begin
          core_err = 1'b1;
          core_quotient = '0;
          core_remainder = '0;
        end else begin
          core_err = 1'b0;
          core_quotient = W'(dm / v);
          core_remainder = W'(dm % v);
        end
        cnt = 3;
      end
    end
  end

  // arithmetic reference for the requirements
  task automatic model(input bit sgn, input bit byt, input longint dvd_raw,
                       input longint dvs_raw, output bit e, output longint q,
                       output longint r, output longint cdvd, output longint cdvs);
    int     n;
    longint dm, vm, sd, sv, md, mv, qq, rr, qs, rs;
    n  = byt ? HB : W;
    dm = dvd_raw & ((64'd1 << (2 * n)) - 1);
    vm = dvs_raw & ((64'd1 << n) - 1);
    sd = dm;
    sv = vm;
    if (sgn && dm[2*n-1]) sd = dm - (64'd1 << (2 * n));
    if (sgn && vm[n-1])   sv = vm - (64'd1 << n);
    md = (sd < 0) ? -sd : sd;
    mv = (sv < 0) ? -sv : sv;
    cdvd = md;
    cdvs = mv;
    e = 1'b0; q = 0; r = 0;
    if ((md >> n) >= mv) begin
      e = 1'b1;
      return;
    end
    qq = md / mv;
    rr = md % mv;
    if (sgn && qq >= (64'd1 << (n - 1))) begin
      e = 1'b1;
      return;
    end
    qs = (sgn && ((sd < 0) != (sv < 0))) ? -qq : qq;
    rs = (sgn && (sd < 0)) ? -rr : rr;
    q = qs & ((64'd1 << n) - 1);
    r = rs & ((64'd1 << n) - 1);
  endtask

  task automatic run_op(input bit sgn, input bit byt, input logic [2*W-1:0] dvd,
                        input logic [W-1:0] dvs, input bit timing);
    bit     e;
    longint q, r, cd, cv;
    string  req;
    bit     got;
    model(sgn, byt, longint'(dvd), longint'(dvs), e, q, r, cd, cv);
    exp_cdvd = cd;
    exp_cdvs = cv;
    @(negedge clk);
    is_signed = sgn;
    byte_mode = byt;
    dividend  = dvd;
    divisor   = dvs;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (timing) chk(core_start == 1'b1, "R7", "core_start after accept", core_start, 1);
    got = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    obs_q = quotient;
    obs_r = remainder;
    obs_e = div_err;
    if (!got) begin
      chk(1'b0, "R7", "timeout waiting for done", 0, 1);
      return;
    end
    if (timing) chk(cyc == core_done_cyc + 1, "R7", "done one cycle after core_done",
                    cyc - core_done_cyc, 1);
    req = byt ? "R6" : (e ? "R4" : (sgn ? "R2" : "R1"));
    chk(div_err == e, req, "div_err", div_err, e);
    chk(longint'(quotient) == q && longint'(remainder) == r, req,
        "quotient/remainder", {quotient, remainder}, {q[W-1:0], r[W-1:0]});
  endtask

  function automatic logic [2*W-1:0] word_pick(input int k);
    case (k)
      0: return 16'h0000;   1: return 16'h8000;
      2: return 16'hFFFF;   3: return 16'h7FFF;
      4: return 16'h0100;   5: return 16'hFF00;
      6: return 16'h0001;   7: return 16'hFFE5;
      8: return 16'h001B;   9: return 16'h4000;
      10: return 16'hC000;  11: return 16'h00FF;
      12: return 16'hFF01;  13: return 16'h3FC0;
      14: return 16'hC040;  default: return 16'h1234;
    endcase
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nfail, nchk);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(done == 0 && div_err == 0 && core_start == 0, "R10", "control outputs",
        {done, div_err, core_start}, 0);
    chk(quotient == 0 && remainder == 0 && flag_carry == 0 && flag_ovf == 0,
        "R10", "data outputs", {quotient, remainder, flag_carry, flag_ovf}, 0);

    // R2: signed truncation cases
    run_op(1, 0, 16'hFFE5, 8'h07, 1);
    chk(obs_q == 8'hFD && obs_r == 8'hFA, "R2", "-27/7", {obs_q, obs_r}, 16'hFDFA);
    // R8: flags after a signed divide
    chk(flag_carry == 0 && flag_ovf == 0, "R8", "flags", {flag_carry, flag_ovf}, 0);
    run_op(1, 0, 16'h001B, 8'hF9, 0);
    chk(obs_q == 8'hFD && obs_r == 8'h06, "R2", "27/-7", {obs_q, obs_r}, 16'hFD06);
    run_op(1, 0, 16'hFFE5, 8'hF9, 0);
    chk(obs_q == 8'h03 && obs_r == 8'hFA, "R2", "-27/-7", {obs_q, obs_r}, 16'h03FA);

    // R3: overflow, including the most negative quotient
    run_op(1, 0, 16'hFF00, 8'h02, 0);
    chk(obs_e == 1, "R3", "-256/2 rejected", obs_e, 1);
    run_op(1, 0, 16'h0080, 8'h01, 0);
    chk(obs_e == 1, "R3", "128/1 rejected", obs_e, 1);
    run_op(1, 0, 16'hFF80, 8'hFF, 0);
    chk(obs_e == 1, "R3", "-128/-1 rejected", obs_e, 1);
    run_op(1, 0, 16'hFF81, 8'h01, 0);
    chk(obs_e == 0 && obs_q == 8'h81, "R3", "-127/1 accepted", {obs_e, obs_q}, 9'h081);
    // R1: unsigned skips the signed overflow test
    run_op(0, 0, 16'h0080, 8'h01, 0);
    chk(obs_e == 0 && obs_q == 8'h80, "R1", "unsigned 128/1", {obs_e, obs_q}, 9'h080);
    // R4 and R5: zero divisor and core rejection
    run_op(1, 0, 16'h0005, 8'h00, 0);
    chk(obs_e == 1 && obs_q == 0 && obs_r == 0, "R5", "divide by zero",
        {obs_e, obs_q, obs_r}, 17'h10000);
    run_op(0, 0, 16'h0300, 8'h03, 0);
    chk(obs_e == 1, "R4", "upper half equals divisor", obs_e, 1);
    // R6: byte mode with junk in the unused bits
    run_op(1, 1, 16'h5AF9, 8'hA2, 0);
    chk(obs_q == 8'h0D && obs_r == 8'h0F, "R6", "byte -7/2", {obs_q, obs_r}, 16'h0D0F);

    // R7: a start while busy is ignored
    s0 = starts;
    model(1, 0, 16'hFFE5, 8'h07, obs_e, exp_cdvd, exp_cdvd, exp_cdvd, exp_cdvs);
    exp_cdvd = 27;
    exp_cdvs = 7;
    @(negedge clk);
    is_signed = 1; byte_mode = 0; dividend = 16'hFFE5; divisor = 8'h07; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    dividend = 16'h0040; divisor = 8'h03; is_signed = 0; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 30; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done == 1 && quotient == 8'hFD && remainder == 8'hFA, "R7",
        "result of first op kept", {done, quotient, remainder}, 17'h1FDFA);
    repeat (8) @(negedge clk);
    chk(starts == s0 + 1 && done == 0, "R7", "no second core request",
        starts - s0, 1);

    // sweeps: byte mode exhaustive, word mode over chosen dividends
    for (int sg = 0; sg < 2; sg++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 16; b++)
          run_op(sg[0], 1, {8'hC3, a[7:0]}, {4'h9, b[3:0]}, 0);
    for (int sg = 0; sg < 2; sg++)
      for (int k = 0; k < 16; k++)
        for (int b = 0; b < 256; b++)
          run_op(sg[0], 0, word_pick(k), b[7:0], 0);

    $display("Result: errors=%0d of %0d checks", nfail, nchk);
    $finish;
  end
endmodule